// File: doc/BRIEF.md
# Fall-Through Bubble FIFO

This block is an elastic first-in first-out store of sixteen 4-bit words. It is built as a chain of word stages, and each stage carries an occupancy marker. A word written at the input end falls through the chain one stage per clock until it reaches the last vacant stage nearest the output. Vacant slots move the other way, toward the input end. There are no read or write pointers and no RAM. Each stage decides its own move from its neighbours' markers, and all stages update together from the previous state.

The write side takes a shift-in strobe and reports whether the first stage is free. The read side takes a shift-out strobe and reports whether the last stage holds a word. The strobes may come from unrelated logic. Each passes through a two-flop synchronizer and an edge detector inside the clock domain. A word is loaded on a rising edge of shift-in and discarded from the output on a falling edge of shift-out. An output-hold input blocks unloading and forces the data output to an idle zero. A synchronous master reset marks every stage vacant. It leaves the stored data bits unchanged, but those bits are no longer treated as valid.

Top module: `bubble_fifo`

## Requirements
- R1: The block stores up to 16 words of 4 bits. After 16 accepted loads with no unloads, and once the chain has settled, `din_ready` stays at 0.
- R2: When `rst` is high at a rising clock edge, every stage is marked vacant. After that edge `din_ready` is 1 and `dout_ready` is 0, and no word stored before the reset is ever delivered.
- R3: A 0-to-1 change on `shift_in` loads `din` into the first stage at the third rising clock edge after the change, and only if `din_ready` is 1 at that time. Exactly one word is loaded per rising edge of `shift_in`, however long the strobe stays high.
- R4: In an empty FIFO, `din_ready` is 0 after the edge that loads a word. It returns to 1 after the next edge, when the word moves on to the second stage.
- R5: A word can move at most one stage per clock. A word loaded into an empty FIFO makes `dout_ready` rise at the 18th rising clock edge after the rising edge of `shift_in`, and not before. While `dout_ready` is 1, `dout` keeps a stable value.
- R6: A 1-to-0 change on `shift_out` discards the word at the output at the third rising clock edge after the change. This happens only if `dout_ready` is 1 and `out_hold` is 0 at that time. The next stored word then falls through to the output.
- R7: While `out_hold` is 1, unloading is blocked, so `dout_ready` cannot fall, and `dout` reads 0.
- R8: A load attempted while the FIFO is full, and an unload attempted while it is empty, have no effect on the stored words.
- R9: Words leave in the order they were accepted, with no loss and no duplication, even when loads and unloads overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all stages and synchronizers |
| rst | input | 1 | Synchronous active-high master reset (clears markers only) |
| shift_in | input | 1 | Load strobe, acts on its rising edge |
| din | input | 4 | Word to load |
| shift_out | input | 1 | Unload strobe, acts on its falling edge |
| out_hold | input | 1 | High blocks unloading and idles the data output at 0 |
| din_ready | output | 1 | High when the first stage is vacant |
| dout_ready | output | 1 | High when the last stage holds a word |
| dout | output | 4 | Word held in the last stage |

## Verification
The hardest state to reach from the ports is a completely full chain that then receives one more load strobe. The bench also has to show that this extra word never appears, which it can only see after draining all sixteen earlier words. The stimulus fills the chain with distinct words, waits long enough for every bubble to reach the input end, and pulses `shift_in` with a marker value. It then drains the chain through the scoreboard and checks that the output goes empty at the right point. The exact fall-through latency is measured with a single word sampled at fixed edge counts. Overlapping write and read streams exercise a chain where words and bubbles move through each other.

// File: rtl/bubble_fifo_pkg.sv
package bubble_fifo_pkg;
  localparam int unsigned DEF_WORD_W   = 4;
  localparam int unsigned DEF_DEPTH    = 16;
  localparam int unsigned SYNC_FLOPS   = 2;

  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_kind_e;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge
  import bubble_fifo_pkg::*;
#(
  parameter edge_kind_e KIND   = EDGE_RISE,
  parameter int unsigned FLOPS = SYNC_FLOPS
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic pulse
);
  localparam logic IDLE = (KIND == EDGE_FALL) ? 1'b1 : 1'b0;

  logic [FLOPS-1:0] sync_q;
  logic             last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= {FLOPS{IDLE}};
      last_q <= IDLE;
    end else begin
      sync_q <= {sync_q[FLOPS-2:0], strobe};
      last_q <= sync_q[FLOPS-1];
    end
  end

  generate
    if (KIND == EDGE_FALL) begin : g_fall
      assign pulse = last_q & ~sync_q[FLOPS-1];
    end else begin : g_rise
      assign pulse = ~last_q & sync_q[FLOPS-1];
    end
  endgenerate
endmodule

// File: rtl/bubble_stage.sv
module bubble_stage #(
  parameter int unsigned WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_valid,
  input  logic [WORD_W-1:0] fill_data,
  input  logic              drain,
  output logic              occupied,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      occupied <= 1'b0;
    end else if (!occupied && fill_valid) begin
      occupied <= 1'b1;
    end else if (occupied && drain) begin
      occupied <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!occupied && fill_valid) begin
      word <= fill_data;
    end
  end
endmodule

// File: rtl/bubble_fifo.sv
module bubble_fifo
  import bubble_fifo_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned DEPTH  = DEF_DEPTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_in,
  input  logic [WORD_W-1:0] din,
  input  logic              shift_out,
  input  logic              out_hold,
  output logic              din_ready,
  output logic              dout_ready,
  output logic [WORD_W-1:0] dout
);
  localparam int unsigned LAST = DEPTH - 1;

  logic              load_pulse;
  logic              unload_pulse;
  logic              do_load;
  logic              do_unload;
  logic [DEPTH-1:0]  occ;
  logic [WORD_W-1:0] words [DEPTH];

  strobe_edge #(.KIND(EDGE_RISE)) in_edge_i (
    .clk(clk), .rst(rst), .strobe(shift_in), .pulse(load_pulse)
  );

  strobe_edge #(.KIND(EDGE_FALL)) out_edge_i (
    .clk(clk), .rst(rst), .strobe(shift_out), .pulse(unload_pulse)
  );

  assign do_load   = load_pulse & ~occ[0];
  assign do_unload = unload_pulse & occ[LAST] & ~out_hold;

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      logic              f_valid;
      logic [WORD_W-1:0] f_data;
      logic              f_drain;

      if (s == 0) begin : g_head
        assign f_valid = do_load;
        assign f_data  = din;
      end else begin : g_body
        assign f_valid = occ[s-1];
        assign f_data  = words[s-1];
      end

      if (s == LAST) begin : g_tail
        assign f_drain = do_unload;
      end else begin : g_pass
        assign f_drain = ~occ[s+1];
      end

      bubble_stage #(.WORD_W(WORD_W)) stage_i (
        .clk       (clk),
        .rst       (rst),
        .fill_valid(f_valid),
        .fill_data (f_data),
        .drain     (f_drain),
        .occupied  (occ[s]),
        .word      (words[s])
      );
    end
  endgenerate

  assign din_ready  = ~occ[0];
  assign dout_ready = occ[LAST];
  assign dout       = out_hold ? '0 : words[LAST];
endmodule

// File: rtl/bubble_fifo_chk.sv
module bubble_fifo_chk #(
  parameter int unsigned WORD_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              out_hold,
  input logic              din_ready,
  input logic              dout_ready,
  input logic [WORD_W-1:0] dout
);
  a_r2_reset_flags: assert property (@(posedge clk)
    rst |=> (din_ready && !dout_ready));

  a_r5_head_stable: assert property (@(posedge clk) disable iff (rst)
    (dout_ready && !out_hold) |=> (!dout_ready || out_hold || $stable(dout)));

  a_r6_fall_needs_release: assert property (@(posedge clk) disable iff (rst)
    ($fell(dout_ready) && $past(!rst)) |-> $past(!out_hold));

  a_r7_hold_keeps_ready: assert property (@(posedge clk) disable iff (rst)
    (out_hold && dout_ready) |=> dout_ready);

  a_r7_idle_output: assert property (@(posedge clk) disable iff (rst)
    out_hold |-> (dout == '0));
endmodule

bind bubble_fifo bubble_fifo_chk #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst(rst), .out_hold(out_hold),
  .din_ready(din_ready), .dout_ready(dout_ready), .dout(dout)
);

// File: tb/bubble_fifo_tb_top.sv
`timescale 1ns/1ps
module bubble_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       shift_in = 1'b0;
  logic [3:0] din = '0;
  logic       shift_out = 1'b1;
  logic       out_hold = 1'b0;
  logic       din_ready;
  logic       dout_ready;
  logic [3:0] dout;

  int checks = 0;
  int fails  = 0;
  logic [3:0] sb_q[$];

  always #2.5 clk = ~clk;

  bubble_fifo dut_i (
    .clk(clk), .rst(rst), .shift_in(shift_in), .din(din),
    .shift_out(shift_out), .out_hold(out_hold),
    .din_ready(din_ready), .dout_ready(dout_ready), .dout(dout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_word(input logic [3:0] d);
    int waited = 0;
    while (!din_ready && waited < 200) begin tick(1); waited++; end
    check(din_ready, "R3 ready to load", din_ready, 1);
    din = d;
    shift_in = 1'b1;
    sb_q.push_back(d);
    tick(4);
    shift_in = 1'b0;
    tick(4);
  endtask

  task automatic pulse_in_raw(input logic [3:0] d);
    din = d; shift_in = 1'b1; tick(4); shift_in = 1'b0; tick(4);
  endtask

  task automatic pulse_out_raw();
    shift_out = 1'b0; tick(4); shift_out = 1'b1; tick(4);
  endtask

  task automatic pop_word(input string req);
    int waited = 0;
    logic [3:0] exp;
    while (!dout_ready && waited < 400) begin tick(1); waited++; end
    exp = (sb_q.size() > 0) ? sb_q.pop_front() : 4'h0;
    check(dout_ready === 1'b1, req, dout_ready, 1);
    check(dout === exp, req, dout, exp);
    pulse_out_raw();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R2 reset state
    check(din_ready === 1'b1, "R2 din_ready after reset", din_ready, 1);
    check(dout_ready === 1'b0, "R2 dout_ready after reset", dout_ready, 0);

    // R3/R4/R5 exact timing of a single word
    din = 4'hA; shift_in = 1'b1;
    tick(2);
    check(din_ready === 1'b1, "R3 no load before third edge", din_ready, 1);
    tick(1);
    check(din_ready === 1'b0, "R4 ready drops after load", din_ready, 0);
    tick(1);
    check(din_ready === 1'b1, "R4 ready back after move", din_ready, 1);
    tick(13);
    check(dout_ready === 1'b0, "R5 not ready at edge 17", dout_ready, 0);
    tick(1);
    check(dout_ready === 1'b1, "R5 ready at edge 18", dout_ready, 1);
    check(dout === 4'hA, "R5 word at output", dout, 10);
    tick(6);
    check(din_ready === 1'b1, "R3 held strobe loads once", din_ready, 1);
    shift_in = 1'b0;
    tick(2);
    sb_q.push_back(4'hA);
    pop_word("R6 single word");
    tick(4);
    check(dout_ready === 1'b0, "R3 only one word loaded", dout_ready, 0);

    // R1/R8 fill to capacity, then extra load ignored
    for (int i = 0; i < 16; i++) push_word(4'(i));
    tick(40);
    check(din_ready === 1'b0, "R1 full after 16 loads", din_ready, 0);
    pulse_in_raw(4'hF);
    tick(4);
    check(din_ready === 1'b0, "R8 still full after ignored load", din_ready, 0);

    // R7 output hold blocks unload
    out_hold = 1'b1;
    tick(2);
    check(dout === 4'h0, "R7 idle output", dout, 0);
    pulse_out_raw();
    check(dout_ready === 1'b1, "R7 unload blocked", dout_ready, 1);
    out_hold = 1'b0;
    tick(2);
    check(dout === 4'h0, "R7 first word kept", dout, 0);

    for (int i = 0; i < 16; i++) pop_word("R9 drain order");
    tick(40);
    check(dout_ready === 1'b0, "R8 ignored word absent", dout_ready, 0);
    check(din_ready === 1'b1, "R1 empty after drain", din_ready, 1);

    // R8 unload while empty
    pulse_out_raw();
    push_word(4'h5);
    tick(30);
    pop_word("R8 empty unload had no effect");
    tick(30);
    check(dout_ready === 1'b0, "R8 nothing extra", dout_ready, 0);

    // R2 reset discards stored words
    push_word(4'h3); push_word(4'h9); push_word(4'hC);
    tick(30);
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    check(din_ready === 1'b1, "R2 din_ready after mid reset", din_ready, 1);
    check(dout_ready === 1'b0, "R2 dout_ready after mid reset", dout_ready, 0);
    sb_q.delete();
    push_word(4'h6); push_word(4'h7);
    pop_word("R2 new data after reset");
    pop_word("R2 new data after reset");
    tick(30);
    check(dout_ready === 1'b0, "R2 old words gone", dout_ready, 0);

    // R9 overlapping streams
    fork
      begin
        for (int i = 0; i < 40; i++) push_word(4'((i * 7 + 3) % 16));
      end
      begin
        for (int i = 0; i < 40; i++) begin
          pop_word("R9 overlapped order");
          if (i % 5 == 0) tick(20);
        end
      end
    join
    tick(40);
    check(dout_ready === 1'b0, "R9 no duplicate", dout_ready, 0);
    check(sb_q.size() == 0, "R9 no loss", sb_q.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule